// File: doc/BRIEF.md
# Multi-Pipe Interrupt Aggregator

This block gathers interrupt events from a set of DMA pipes and from a controller's global fault and timer logic, and turns them into one level-high interrupt line for each execution environment (software context) that shares the controller. Each pipe keeps a small sticky status word, an enable word and a write-one-to-clear port. Each pipe's enabled pending state becomes one bit of a 32-bit source word. Bit 31 of that word carries the enabled global events.

Every environment has its own mask over the source word and its own copy of the source word to read. Its line stays high while any source that it has unmasked is pending. Software reads the source word to find which pipe raised the line, clears that pipe's status bits, and the line drops once nothing unmasked is left. All access goes through a simple register port. A write takes effect at the clock edge where it is presented. Read data appears on the next cycle.

Register map (byte addresses): 0x004 identity (environment count in bits 11:8), 0x008 pipe count (bits 7:0), 0x010 global status, 0x014 global enable, 0x018 global clear, 0x800 + 0x80·e environment e source word, 0x804 + 0x80·e environment e mask, 0x1000 + 0x100·p pipe p status, +0x4 pipe enable, +0x8 pipe clear.

Top module: `intr_aggregator`

## Requirements
- R1: After reset, every status, enable and mask register reads zero and every interrupt line is low.
- R2: A high pulse on a pipe event input sets the matching sticky status bit, and the bit stays set after the pulse. The bit positions are: 0 descriptor done, 1 timer, 2 wake, 3 out of descriptors, 4 error, 5 transfer end.
- R3: Writing a value to a pipe's or the global clear register clears exactly the status bits set in that value, and leaves the other bits unchanged. A clear register reads zero.
- R4: When an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R5: Source bit p equals the OR over pipe p's status bits ANDed with its enable bits. A disabled event is still recorded in status.
- R6: Global status uses bit 4 for timer, bit 3 for empty, bit 2 for error and bit 1 for bus response error. Enable and clear use the same positions. Source bit 31 is the OR of the global status bits ANDed with the global enable bits.
- R7: The line for environment e is high exactly when the source word ANDed with e's mask is nonzero. Every environment reads the same unmasked source word.
- R8: A line stays high until every unmasked pending source has been cleared or masked.
- R9: The identity register returns the environment count in bits 11:8. The pipe-count register returns the pipe count in bits 7:0.
- R10: Writes to source words and to unmapped addresses have no effect. Reads of unmapped addresses return zero. Read data is zero in any cycle that follows a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pipe_evt_i | input | NUM_PIPES*6 | Event pulses, six per pipe, pipe p at bits 6p+5:6p |
| glob_evt_i | input | 4 | Global event pulses for status bits 4:1 |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read |
| irq_o | output | NUM_ENVS | Level-high interrupt line per environment |

## Verification
The pipe path is tried with events that arrive while their enable is off and then while it is on. This separates recording an event from reporting it. Partial clears on a word with two bits set show that a line holds while one unmasked cause remains. A clear that lands in the same cycle as a new event checks the priority between the two. The global path drives one environment while the other stays masked, which confirms that masking is kept per environment. Two pipes are then raised at once and cleared one at a time, which shows that the line drops only when the last unmasked source is gone.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
    localparam int unsigned SRC_W        = 32;
    localparam int unsigned SRC_GLOB_BIT = 31;
    localparam int unsigned PIPE_EVT_W   = 6;
    localparam int unsigned GLOB_EVT_W   = 4;
    localparam int unsigned GLOB_LSB     = 1;

    localparam int unsigned OFS_IDENT    = 32'h0004;
    localparam int unsigned OFS_PCOUNT   = 32'h0008;
    localparam int unsigned OFS_GSTAT    = 32'h0010;
    localparam int unsigned OFS_GEN      = 32'h0014;
    localparam int unsigned OFS_GCLR     = 32'h0018;

    localparam int unsigned ENV_BASE     = 32'h0800;
    localparam int unsigned ENV_STRIDE   = 32'h0080;
    localparam int unsigned ENV_SRC      = 32'h0000;
    localparam int unsigned ENV_MASK     = 32'h0004;

    localparam int unsigned PIPE_BASE    = 32'h1000;
    localparam int unsigned PIPE_STRIDE  = 32'h0100;
    localparam int unsigned PIPE_STAT    = 32'h0000;
    localparam int unsigned PIPE_EN      = 32'h0004;
    localparam int unsigned PIPE_CLR     = 32'h0008;
endpackage

// File: rtl/intr_evt_bank.sv
module intr_evt_bank #(
    parameter int unsigned W = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] evt_i,
    input  logic         en_we_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] en_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we_i) begin
            st_d.stat = st_q.stat & ~wdata_i;
        end
        // new events take priority over a clear in the same cycle
        st_d.stat = st_d.stat | evt_i;
        if (en_we_i) begin
            st_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign en_o   = st_q.en;
    assign pend_o = |(st_q.stat & st_q.en);
endmodule

// File: rtl/intr_env_bank.sv
module intr_env_bank
    import intr_agg_pkg::*;
#(
    parameter int unsigned NUM_ENVS = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_ENVS-1:0]       mask_we_i,
    input  logic [SRC_W-1:0]          wdata_i,
    input  logic [SRC_W-1:0]          src_i,
    output logic [NUM_ENVS*SRC_W-1:0] mask_o,
    output logic [NUM_ENVS-1:0]       irq_o
);
    typedef struct packed {
        logic [NUM_ENVS-1:0][SRC_W-1:0] mask;
    } env_t;

    env_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < int'(NUM_ENVS); e++) begin
            if (mask_we_i[e]) st_d.mask[e] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar e = 0; e < NUM_ENVS; e++) begin : g_line
        assign irq_o[e] = |(src_i & st_q.mask[e]);
        assign mask_o[e*SRC_W +: SRC_W] = st_q.mask[e];
    end
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
    import intr_agg_pkg::*;
#(
    parameter int unsigned NUM_PIPES = 4,
    parameter int unsigned NUM_ENVS  = 2,
    parameter int unsigned ADDR_W    = 16
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic [NUM_PIPES*PIPE_EVT_W-1:0] pipe_evt_i,
    input  logic [GLOB_EVT_W-1:0]           glob_evt_i,
    input  logic                            wr_en_i,
    input  logic                            rd_en_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [SRC_W-1:0]                wdata_i,
    output logic [SRC_W-1:0]                rdata_o,
    output logic [NUM_ENVS-1:0]             irq_o
);
    localparam int unsigned PSTAT_W = NUM_PIPES * PIPE_EVT_W;

    logic [PSTAT_W-1:0]        pipe_stat, pipe_en;
    logic [NUM_PIPES-1:0]      pipe_pend, pipe_en_we, pipe_clr_we;
    logic [GLOB_EVT_W-1:0]     glob_stat, glob_en;
    logic                      glob_pend, glob_en_we, glob_clr_we;
    logic [NUM_ENVS-1:0]       env_mask_we;
    logic [NUM_ENVS*SRC_W-1:0] env_mask;
    logic [SRC_W-1:0]          src_word, rd_word;

    typedef struct packed {
        logic [SRC_W-1:0] rdata;
    } top_t;

    top_t st_d, st_q;

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        intr_evt_bank #(.W(PIPE_EVT_W)) u_bank (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .evt_i    (pipe_evt_i[p*PIPE_EVT_W +: PIPE_EVT_W]),
            .en_we_i  (pipe_en_we[p]),
            .clr_we_i (pipe_clr_we[p]),
            .wdata_i  (wdata_i[PIPE_EVT_W-1:0]),
            .stat_o   (pipe_stat[p*PIPE_EVT_W +: PIPE_EVT_W]),
            .en_o     (pipe_en[p*PIPE_EVT_W +: PIPE_EVT_W]),
            .pend_o   (pipe_pend[p])
        );
    end

    intr_evt_bank #(.W(GLOB_EVT_W)) u_glob (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .evt_i    (glob_evt_i),
        .en_we_i  (glob_en_we),
        .clr_we_i (glob_clr_we),
        .wdata_i  (wdata_i[GLOB_LSB +: GLOB_EVT_W]),
        .stat_o   (glob_stat),
        .en_o     (glob_en),
        .pend_o   (glob_pend)
    );

    always_comb begin
        src_word = '0;
        src_word[NUM_PIPES-1:0] = pipe_pend;
        src_word[SRC_GLOB_BIT]  = glob_pend;
    end

    intr_env_bank #(.NUM_ENVS(NUM_ENVS)) u_env (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mask_we_i (env_mask_we),
        .wdata_i   (wdata_i),
        .src_i     (src_word),
        .mask_o    (env_mask),
        .irq_o     (irq_o)
    );

    // address decode for writes and the read mux
    always_comb begin
        int unsigned a;
        a           = 32'(addr_i);
        pipe_en_we  = '0;
        pipe_clr_we = '0;
        env_mask_we = '0;
        glob_en_we  = wr_en_i && (a == OFS_GEN);
        glob_clr_we = wr_en_i && (a == OFS_GCLR);
        rd_word     = '0;
        if (a == OFS_IDENT)  rd_word = SRC_W'(NUM_ENVS) << 8;
        if (a == OFS_PCOUNT) rd_word = SRC_W'(NUM_PIPES);
        if (a == OFS_GSTAT)  rd_word = SRC_W'(glob_stat) << GLOB_LSB;
        if (a == OFS_GEN)    rd_word = SRC_W'(glob_en) << GLOB_LSB;
        for (int p = 0; p < int'(NUM_PIPES); p++) begin
            int unsigned pb;
            pb = PIPE_BASE + 32'(p) * PIPE_STRIDE;
            if (a == pb + PIPE_EN)  pipe_en_we[p]  = wr_en_i;
            if (a == pb + PIPE_CLR) pipe_clr_we[p] = wr_en_i;
            if (a == pb + PIPE_STAT)
                rd_word = SRC_W'(pipe_stat[p*PIPE_EVT_W +: PIPE_EVT_W]);
            if (a == pb + PIPE_EN)
                rd_word = SRC_W'(pipe_en[p*PIPE_EVT_W +: PIPE_EVT_W]);
        end
        for (int e = 0; e < int'(NUM_ENVS); e++) begin
            int unsigned eb;
            eb = ENV_BASE + 32'(e) * ENV_STRIDE;
            if (a == eb + ENV_MASK) begin
                env_mask_we[e] = wr_en_i;
                rd_word        = env_mask[e*SRC_W +: SRC_W];
            end
            if (a == eb + ENV_SRC) rd_word = src_word;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = rd_en_i ? rd_word : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/intr_agg_chk.sv
module intr_agg_chk
    import intr_agg_pkg::*;
#(
    parameter int unsigned NUM_PIPES = 4,
    parameter int unsigned NUM_ENVS  = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_PIPES*PIPE_EVT_W-1:0] pipe_evt,
    input logic [NUM_PIPES*PIPE_EVT_W-1:0] pipe_stat,
    input logic [GLOB_EVT_W-1:0]           glob_evt,
    input logic [GLOB_EVT_W-1:0]           glob_en,
    input logic [SRC_W-1:0]                src_word,
    input logic [NUM_ENVS*SRC_W-1:0]       env_mask,
    input logic [NUM_ENVS-1:0]             irq,
    input logic                            rd_en,
    input logic [SRC_W-1:0]                rdata
);
    // event always lands in status, even against a clear
    assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|pipe_evt) |=> ((pipe_stat & $past(pipe_evt)) == $past(pipe_evt)));

    // a status bit only rises after an event on it
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pipe_stat & ~$past(pipe_stat) & ~$past(pipe_evt)) == '0));

    // all masks zero keeps every line low
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (env_mask == '0) |-> (irq == '0));

    // enabled global event reaches source bit 31 next cycle
    assert_glob_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(glob_evt & glob_en)) |=> src_word[SRC_GLOB_BIT]);

    // idle port returns zero
    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));
endmodule

bind intr_aggregator intr_agg_chk #(
    .NUM_PIPES (NUM_PIPES),
    .NUM_ENVS  (NUM_ENVS)
) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .pipe_evt  (pipe_evt_i),
    .pipe_stat (pipe_stat),
    .glob_evt  (glob_evt_i),
    .glob_en   (glob_en),
    .src_word  (src_word),
    .env_mask  (env_mask),
    .irq       (irq_o),
    .rd_en     (rd_en_i),
    .rdata     (rdata_o)
);

// File: tb/intr_aggregator_tb.sv
module intr_aggregator_tb;
    localparam int unsigned NP = 4;
    localparam int unsigned NE = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP*6-1:0] pipe_evt = '0;
    logic [3:0]      glob_evt = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [15:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NE-1:0]   irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    intr_aggregator #(.NUM_PIPES(NP), .NUM_ENVS(NE), .ADDR_W(16)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pipe_evt_i(pipe_evt), .glob_evt_i(glob_evt),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [15:0] pa(input int p, input int off);
        return 16'(32'h1000 + p * 32'h100 + off);
    endfunction
    function automatic logic [15:0] ea(input int e, input int off);
        return 16'(32'h800 + e * 32'h80 + off);
    endfunction

    // monitor: pops expected read data one cycle after each read
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
        @(negedge clk);
    endtask

    task automatic pulse(input int p, input logic [5:0] b);
        @(negedge clk);
        pipe_evt[p*6 +: 6] = b;
        @(negedge clk);
        pipe_evt = '0;
    endtask

    task automatic chk_irq(input logic [NE-1:0] e, input string t);
        @(negedge clk);
        tests++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(2'b00, "R1");
        rd(pa(0, 0), 32'h0, "R1 pipe status");
        rd(pa(2, 4), 32'h0, "R1 pipe enable");
        rd(ea(0, 4), 32'h0, "R1 mask");
        rd(16'h0010, 32'h0, "R1 global status");
        // R9 identity
        rd(16'h0004, 32'(NE) << 8, "R9 env count");
        rd(16'h0008, 32'(NP), "R9 pipe count");
        // R2 sticky events, R5 disabled event recorded not reported
        pulse(1, 6'h21);
        rd(pa(1, 0), 32'h21, "R2 sticky status");
        rd(ea(0, 0), 32'h0, "R5 disabled source");
        wr(pa(1, 4), 32'h01);
        rd(pa(1, 4), 32'h01, "R5 enable readback");
        rd(ea(0, 0), 32'h2, "R5 env0 source");
        rd(ea(1, 0), 32'h2, "R7 env1 same source");
        chk_irq(2'b00, "R7 all masked");
        // R7 mask env0
        wr(ea(0, 4), 32'h2);
        chk_irq(2'b01, "R7 env0 unmasked");
        // R3 partial clear
        wr(pa(1, 8), 32'h20);
        rd(pa(1, 0), 32'h01, "R3 partial clear");
        rd(pa(1, 8), 32'h0, "R3 clear reads zero");
        chk_irq(2'b01, "R8 still pending");
        // R4 event and clear together
        @(negedge clk);
        wr_en = 1'b1; addr = pa(1, 8); wdata = 32'h01; pipe_evt[6 +: 6] = 6'h01;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0; pipe_evt = '0;
        rd(pa(1, 0), 32'h01, "R4 event wins");
        chk_irq(2'b01, "R4 line held");
        // R8 final clear
        wr(pa(1, 8), 32'h01);
        rd(pa(1, 0), 32'h0, "R3 full clear");
        chk_irq(2'b00, "R8 line drops");
        // R6 global path, error at bit 2
        @(negedge clk); glob_evt = 4'b0010;
        @(negedge clk); glob_evt = '0;
        rd(16'h0010, 32'h4, "R6 global status bit2");
        wr(16'h0014, 32'h4);
        rd(16'h0014, 32'h4, "R6 global enable");
        rd(ea(0, 0), 32'h8000_0000, "R6 source bit31");
        chk_irq(2'b00, "R7 global masked");
        wr(ea(1, 4), 32'h8000_0000);
        chk_irq(2'b10, "R7 env1 global");
        wr(16'h0018, 32'h4);
        rd(16'h0010, 32'h0, "R6 global clear");
        chk_irq(2'b00, "R6 line drops");
        // R10 read-only and unmapped
        wr(ea(0, 0), 32'hFFFF_FFFF);
        rd(ea(0, 0), 32'h0, "R10 source write ignored");
        wr(16'h0300, 32'hFFFF_FFFF);
        rd(16'h0300, 32'h0, "R10 unmapped read");
        chk_irq(2'b00, "R10 unmapped write");
        // R8 two pipes, cleared one at a time
        pulse(0, 6'h10);
        pulse(3, 6'h08);
        wr(pa(0, 4), 32'h10);
        wr(pa(3, 4), 32'h08);
        wr(ea(1, 4), 32'h8000_0009);
        rd(ea(1, 0), 32'h9, "R5 two sources");
        chk_irq(2'b10, "R7 two pipes");
        wr(pa(0, 8), 32'h10);
        chk_irq(2'b10, "R8 one left");
        wr(pa(3, 8), 32'h08);
        chk_irq(2'b00, "R8 none left");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule